// File: doc/BRIEF.md
# Directory Coherence Transaction Controller

This block sits at the home node of a coherent memory system. For each address that cores are working on, it runs a small state machine. Core requests arrive on one input. For a read-class request, the block sends the memory read and the probe broadcast in the same cycle. It then waits for two things: the memory data (or a last-level-cache hit) and the probe completion. These may arrive in either order. When both have arrived, it returns a Shared, Exclusive or Modified grant to the requester, then holds the address until that requester sends an unblock.

Dirty and clean victims are acknowledged as soon as they are accepted. The block then waits for the victim data and writes it to memory.

A small table of concurrent transactions is matched by address. A request to an address the table already holds is stalled with `req_ready` low. The requester retries that request and it is accepted once the entry has returned to idle. Network routing and real memory timing are not part of the block.

Top module: `dir_txn_ctrl`

## Requirements
- R1: While reset is asserted, the registered outputs `resp_valid`, `mrd_valid`, `mwr_valid`, `prb_valid` and `err` read 0. With an empty table, `req_ready` is 1.
- R2: An accepted request with a known type produces outputs in the following cycle, at the request address.
  - Types 0 to 5 produce a probe. `prb_inv` is 0 for read-shared (0) and plain read (1). It is 1 for read-modify (2), change-to-dirty (3), write-through (4) and atomic (5).
  - Types 0, 1, 2, 4 and 5 also produce a memory read. Change-to-dirty does not.
- R3: A read-class transaction completes when both the memory data and the probe-completion response (`rsp_kind`=1) have been seen, in either order or in the same cycle. After completion, a response is issued to the original requester when the output is free.
- R4: The response kind is encoded on `resp_kind`.
  - Read-shared gets Shared (0).
  - Read-modify, change-to-dirty and atomic get Modified (2).
  - A plain read gets Shared if any probe response for it carried `rsp_hit`, or if the request had `req_fshr` set. Otherwise it gets Exclusive (1).
- R5: After a data response, the address stays busy until an unblock for it arrives. While it is busy, `req_ready` is 0 for requests to that address. After the unblock, `req_ready` returns to 1 for that address.
- R6: `req_ready` is 0 in two cases: the request address matches a busy entry, or all `SLOTS` (4) entries are busy. A stalled request may be presented again and is accepted once the condition clears.
- R7: A victim request (type 6 dirty, type 7 clean) is acknowledged with kind WBACK (3) in the next cycle. The following victim-data response (`rsp_kind`=2) produces a memory write at that address in the next cycle and frees the entry.
- R8: While a victim is waiting for its data, any further request to the same address is stalled.
- R9: A write-through gets a WBACK acknowledgment in the cycle after it is accepted. On completion it issues no data response and frees its entry without an unblock.
- R10: An atomic issues a Modified response and then frees its entry without waiting for an unblock.
- R11: A memory input flagged as a writeback acknowledgment (`mem_wback`=1) has no effect on any transaction.
- R12: A request with a type of 8 or above is accepted under the same conditions as any other request. It raises `err` for one cycle and allocates nothing.
- R13: Arbitration for the response output works as follows.
  - An acknowledgment for a request accepted this cycle has the highest priority.
  - Data responses waiting at the same time leave in slot order, lowest first.
  - New transactions take the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_type | input | 4 | Request type code, 0 to 7 (see R2, R7) |
| req_addr | input | AW | Block address |
| req_src | input | SW | Requester identifier |
| req_fshr | input | 1 | Requester asks for a Shared grant |
| rsp_valid | input | 1 | Core response present |
| rsp_kind | input | 2 | 0 probe ack, 1 probes complete, 2 victim data |
| rsp_addr | input | AW | Response address |
| rsp_hit | input | 1 | Probed cache held the line |
| mem_valid | input | 1 | Memory or cache message present |
| mem_wback | input | 1 | Message is a writeback acknowledgment |
| mem_addr | input | AW | Memory message address |
| unb_valid | input | 1 | Requester unblock present |
| unb_addr | input | AW | Unblock address |
| resp_valid | output | 1 | Response to a core |
| resp_kind | output | 2 | 0 Shared, 1 Exclusive, 2 Modified, 3 WBACK |
| resp_addr | output | AW | Response address |
| resp_dst | output | SW | Destination requester |
| mrd_valid | output | 1 | Memory read request |
| mrd_addr | output | AW | Memory read address |
| mwr_valid | output | 1 | Memory write of victim data |
| mwr_addr | output | AW | Memory write address |
| prb_valid | output | 1 | Probe broadcast |
| prb_inv | output | 1 | Probe invalidates (1) or downgrades (0) |
| prb_addr | output | AW | Probe address |
| err | output | 1 | Unknown request type dropped |

## Verification
A slot stuck in the wrong transient state shows up at the ports in one of two ways. It may issue a response one cycle too early, for example when only the memory data has arrived. Or it may issue no response at all, and `req_ready` then stays low for its address. Both show within a cycle or two of the event that should have completed the transaction. A wrong class or hit record shows as a wrong `resp_kind` on the first response. A slot that frees too early or too late shows as `req_ready` disagreeing with the reference model. Because the bench compares every output on every clock, each such fault is reported in the cycle it first becomes visible.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WB,
        ST_SHR_M,  ST_MOD_M,  ST_RD_M,
        ST_SHR_PM, ST_MOD_PM, ST_RD_PM,
        ST_SHR_P,  ST_MOD_P,  ST_RD_P,
        ST_CTD_P,
        ST_SEND,
        ST_BLOCK
    } slot_st_t;

    localparam logic [3:0] RQ_RD_SHR = 4'd0;
    localparam logic [3:0] RQ_RD     = 4'd1;
    localparam logic [3:0] RQ_RD_MOD = 4'd2;
    localparam logic [3:0] RQ_CTD    = 4'd3;
    localparam logic [3:0] RQ_WTHRU  = 4'd4;
    localparam logic [3:0] RQ_ATOMIC = 4'd5;
    localparam logic [3:0] RQ_VIC_D  = 4'd6;
    localparam logic [3:0] RQ_VIC_C  = 4'd7;

    localparam logic [1:0] RI_ACK   = 2'd0;
    localparam logic [1:0] RI_DONE  = 2'd1;
    localparam logic [1:0] RI_VDATA = 2'd2;

    localparam logic [1:0] RS_SHARED = 2'd0;
    localparam logic [1:0] RS_EXCL   = 2'd1;
    localparam logic [1:0] RS_MOD    = 2'd2;
    localparam logic [1:0] RS_WBACK  = 2'd3;

    function automatic logic known_type(input logic [3:0] t);
        return t <= RQ_VIC_C;
    endfunction

    function automatic logic is_victim(input logic [3:0] t);
        return (t == RQ_VIC_D) || (t == RQ_VIC_C);
    endfunction

    function automatic logic needs_mem(input logic [3:0] t);
        return (t <= RQ_ATOMIC) && (t != RQ_CTD);
    endfunction

    function automatic logic inv_probe(input logic [3:0] t);
        return (t >= RQ_RD_MOD) && (t <= RQ_ATOMIC);
    endfunction

    function automatic slot_st_t start_st(input logic [3:0] t);
        case (t)
            RQ_RD_SHR:          return ST_SHR_PM;
            RQ_RD:              return ST_RD_PM;
            RQ_CTD:             return ST_CTD_P;
            RQ_VIC_D, RQ_VIC_C: return ST_WB;
            default:            return ST_MOD_PM;
        endcase
    endfunction

    // memory arrived first: only probes remain
    function automatic slot_st_t after_mem(input slot_st_t s);
        case (s)
            ST_SHR_PM: return ST_SHR_P;
            ST_MOD_PM: return ST_MOD_P;
            ST_RD_PM:  return ST_RD_P;
            default:   return s;
        endcase
    endfunction

    // probes completed first: only memory remains
    function automatic slot_st_t after_prb(input slot_st_t s);
        case (s)
            ST_SHR_PM: return ST_SHR_M;
            ST_MOD_PM: return ST_MOD_M;
            ST_RD_PM:  return ST_RD_M;
            default:   return s;
        endcase
    endfunction

endpackage

// File: rtl/dct_pick.sv
module dct_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh,
    output logic         any
);
    always_comb begin
        oh = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (oh == '0)) oh[i] = 1'b1;
        end
    end
    assign any = |req;
endmodule

// File: rtl/dct_slot.sv
module dct_slot
    import dct_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic [3:0]    a_type,
    input  logic [AW-1:0] a_addr,
    input  logic [SW-1:0] a_src,
    input  logic          a_fshr,
    input  logic [AW-1:0] req_addr,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_kind,
    input  logic [AW-1:0] rsp_addr,
    input  logic          rsp_hit,
    input  logic          mem_valid,
    input  logic          mem_wback,
    input  logic [AW-1:0] mem_addr,
    input  logic          unb_valid,
    input  logic [AW-1:0] unb_addr,
    input  logic          grant,
    output logic          busy,
    output logic          conflict,
    output logic          want_send,
    output logic          vic_done,
    output logic [AW-1:0] s_addr,
    output logic [SW-1:0] s_src,
    output logic [1:0]    s_kind
);
    slot_st_t   st, st_n, done_st;
    logic [3:0] cls;
    logic       shr;
    logic       m, p, h, vd, u;

    assign busy     = (st != ST_IDLE);
    assign conflict = busy && (req_addr == s_addr);
    assign m  = busy && mem_valid && !mem_wback && (mem_addr == s_addr);
    assign p  = busy && rsp_valid && (rsp_kind == RI_DONE) && (rsp_addr == s_addr);
    assign h  = busy && rsp_valid && rsp_hit && (rsp_kind != RI_VDATA) && (rsp_addr == s_addr);
    assign vd = busy && rsp_valid && (rsp_kind == RI_VDATA) && (rsp_addr == s_addr);
    assign u  = busy && unb_valid && (unb_addr == s_addr);

    assign done_st   = (cls == RQ_WTHRU) ? ST_IDLE : ST_SEND;
    assign want_send = (st == ST_SEND);
    assign vic_done  = vd && (st == ST_WB);

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:  if (alloc) st_n = start_st(a_type);
            ST_WB:    if (vd) st_n = ST_IDLE;
            ST_SHR_PM, ST_MOD_PM, ST_RD_PM: begin
                if (m && p)  st_n = done_st;
                else if (m)  st_n = after_mem(st);
                else if (p)  st_n = after_prb(st);
            end
            ST_SHR_P, ST_MOD_P, ST_RD_P, ST_CTD_P: if (p) st_n = done_st;
            ST_SHR_M, ST_MOD_M, ST_RD_M:           if (m) st_n = done_st;
            ST_SEND:  if (grant) st_n = (cls == RQ_ATOMIC) ? ST_IDLE : ST_BLOCK;
            ST_BLOCK: if (u) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_comb begin
        case (cls)
            RQ_RD_SHR: s_kind = RS_SHARED;
            RQ_RD:     s_kind = shr ? RS_SHARED : RS_EXCL;
            default:   s_kind = RS_MOD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cls    <= '0;
            shr    <= 1'b0;
            s_addr <= '0;
            s_src  <= '0;
        end else begin
            st <= st_n;
            if (alloc && !busy) begin
                cls    <= a_type;
                shr    <= a_fshr;
                s_addr <= a_addr;
                s_src  <= a_src;
            end else if (h) begin
                shr <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_txn_ctrl.sv
module dir_txn_ctrl
    import dct_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SW    = 4,
    parameter int SLOTS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_src,
    input  logic          req_fshr,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_kind,
    input  logic [AW-1:0] rsp_addr,
    input  logic          rsp_hit,
    input  logic          mem_valid,
    input  logic          mem_wback,
    input  logic [AW-1:0] mem_addr,
    input  logic          unb_valid,
    input  logic [AW-1:0] unb_addr,
    output logic          resp_valid,
    output logic [1:0]    resp_kind,
    output logic [AW-1:0] resp_addr,
    output logic [SW-1:0] resp_dst,
    output logic          mrd_valid,
    output logic [AW-1:0] mrd_addr,
    output logic          mwr_valid,
    output logic [AW-1:0] mwr_addr,
    output logic          prb_valid,
    output logic          prb_inv,
    output logic [AW-1:0] prb_addr,
    output logic          err
);
    logic [SLOTS-1:0]         busy_v, conf_v, send_v, vic_v;
    logic [SLOTS-1:0]         free_oh, send_oh, alloc_v, grant_v;
    logic                     any_free, any_send;
    logic [SLOTS-1:0][AW-1:0] s_addr;
    logic [SLOTS-1:0][SW-1:0] s_src;
    logic [SLOTS-1:0][1:0]    s_kind;
    logic                     accept, known, ack_now;
    logic [AW-1:0]            sel_addr;
    logic [SW-1:0]            sel_src;
    logic [1:0]               sel_kind;

    dct_pick #(.N(SLOTS)) u_free (.req(~busy_v), .oh(free_oh), .any(any_free));
    dct_pick #(.N(SLOTS)) u_send (.req(send_v), .oh(send_oh), .any(any_send));

    assign req_ready = any_free && !(|conf_v);
    assign accept    = req_valid && req_ready;
    assign known     = known_type(req_type);
    assign ack_now   = accept && known && (is_victim(req_type) || (req_type == RQ_WTHRU));
    assign alloc_v   = (accept && known) ? free_oh : '0;
    assign grant_v   = ack_now ? '0 : send_oh;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        dct_slot #(.AW(AW), .SW(SW)) u_slot (
            .clk(clk), .rst(rst),
            .alloc(alloc_v[g]), .a_type(req_type), .a_addr(req_addr),
            .a_src(req_src), .a_fshr(req_fshr), .req_addr(req_addr),
            .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
            .rsp_hit(rsp_hit), .mem_valid(mem_valid), .mem_wback(mem_wback),
            .mem_addr(mem_addr), .unb_valid(unb_valid), .unb_addr(unb_addr),
            .grant(grant_v[g]), .busy(busy_v[g]), .conflict(conf_v[g]),
            .want_send(send_v[g]), .vic_done(vic_v[g]),
            .s_addr(s_addr[g]), .s_src(s_src[g]), .s_kind(s_kind[g])
        );
    end

    always_comb begin
        sel_addr = '0;
        sel_src  = '0;
        sel_kind = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (send_oh[i]) begin
                sel_addr = sel_addr | s_addr[i];
                sel_src  = sel_src  | s_src[i];
                sel_kind = sel_kind | s_kind[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_kind  <= '0;
            resp_addr  <= '0;
            resp_dst   <= '0;
            mrd_valid  <= 1'b0;
            mrd_addr   <= '0;
            mwr_valid  <= 1'b0;
            mwr_addr   <= '0;
            prb_valid  <= 1'b0;
            prb_inv    <= 1'b0;
            prb_addr   <= '0;
            err        <= 1'b0;
        end else begin
            resp_valid <= ack_now || any_send;
            resp_kind  <= ack_now ? RS_WBACK : sel_kind;
            resp_addr  <= ack_now ? req_addr : sel_addr;
            resp_dst   <= ack_now ? req_src  : sel_src;
            mrd_valid  <= accept && known && needs_mem(req_type);
            mrd_addr   <= req_addr;
            mwr_valid  <= |vic_v;
            mwr_addr   <= rsp_addr;
            prb_valid  <= accept && known && !is_victim(req_type);
            prb_inv    <= inv_probe(req_type);
            prb_addr   <= req_addr;
            err        <= accept && !known;
        end
    end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic [3:0]   req_type,
    input logic [N-1:0] busy_v,
    input logic         resp_valid,
    input logic [1:0]   resp_kind,
    input logic         mrd_valid,
    input logic         prb_valid,
    input logic         err
);
    a_r6_full_stalls: assert property (@(posedge clk) disable iff (rst)
        ($countones(busy_v) == N) |-> !req_ready);

    a_r2_probe_from_accept: assert property (@(posedge clk) disable iff (rst)
        prb_valid |-> $past(req_valid && req_ready && (req_type < 4'd6)));

    a_r2_read_from_accept: assert property (@(posedge clk) disable iff (rst)
        mrd_valid |-> $past(req_valid && req_ready && (req_type inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5})));

    a_r9_early_ack: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == 2'd3) |-> $past(req_valid && req_ready && (req_type inside {4'd4, 4'd6, 4'd7})));

    a_r12_err_source: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(req_valid && req_ready && (req_type >= 4'd8)));
endmodule

bind dir_txn_ctrl dct_checker #(.N(SLOTS)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .busy_v(busy_v), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .mrd_valid(mrd_valid), .prb_valid(prb_valid),
    .err(err)
);

// File: tb/test_dir_txn_ctrl.sv
module test_dir_txn_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SW = 4;
    localparam int N  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_fshr = 0, rsp_valid = 0, rsp_hit = 0;
    logic mem_valid = 0, mem_wback = 0, unb_valid = 0;
    logic [3:0] req_type = 0;
    logic [AW-1:0] req_addr = 0, rsp_addr = 0, mem_addr = 0, unb_addr = 0;
    logic [SW-1:0] req_src = 0;
    logic [1:0] rsp_kind = 0;
    logic req_ready, resp_valid, mrd_valid, mwr_valid, prb_valid, prb_inv, err;
    logic [1:0] resp_kind;
    logic [AW-1:0] resp_addr, mrd_addr, mwr_addr, prb_addr;
    logic [SW-1:0] resp_dst;

    dir_txn_ctrl #(.AW(AW), .SW(SW), .SLOTS(N)) i_dir_txn_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_src(req_src),
        .req_fshr(req_fshr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .mem_valid(mem_valid),
        .mem_wback(mem_wback), .mem_addr(mem_addr), .unb_valid(unb_valid),
        .unb_addr(unb_addr), .resp_valid(resp_valid), .resp_kind(resp_kind),
        .resp_addr(resp_addr), .resp_dst(resp_dst), .mrd_valid(mrd_valid),
        .mrd_addr(mrd_addr), .mwr_valid(mwr_valid), .mwr_addr(mwr_addr),
        .prb_valid(prb_valid), .prb_inv(prb_inv), .prb_addr(prb_addr), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;

    // reference model: phase 0 free, 1 victim wait, 2 wait mem+probes,
    // 3 wait mem, 4 wait probes, 5 ready to send, 6 wait unblock
    int m_ph[N], m_cls[N], m_addr[N], m_src[N], m_shr[N];
    int e_rv = 0, e_rk = 0, e_ra = 0, e_rd = 0;
    int e_mrd = 0, e_mra = 0, e_mwr = 0, e_mwa = 0;
    int e_prb = 0, e_inv = 0, e_pa = 0, e_err = 0;
    int resp_count = 0, last_kind = -1, last_addr = -1, last_mwr = 0, last_err = 0;
    int seen_ready = 0;
    int log_addr[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_ready();
        int nfree = 0;
        for (int i = 0; i < N; i++) begin
            if (m_ph[i] == 0) nfree++;
            else if (m_addr[i] == int'(req_addr)) return 0;
        end
        return (nfree > 0) ? 1 : 0;
    endfunction

    function automatic int kind_of(input int c, input int s);
        if (c == 0) return 0;
        if (c == 1) return s ? 0 : 1;
        return 2;
    endfunction

    task automatic model_step();
        int o_ph[N];
        int t, acc, known, ack, gi, fi;
        if (rst) begin
            for (int i = 0; i < N; i++) m_ph[i] = 0;
            e_rv = 0; e_mrd = 0; e_mwr = 0; e_prb = 0; e_err = 0;
            return;
        end
        for (int i = 0; i < N; i++) o_ph[i] = m_ph[i];
        t = int'(req_type);
        acc = req_valid && model_ready();
        known = (t < 8);
        ack = acc && known && (t == 4 || t == 6 || t == 7);
        gi = -1;
        if (!ack) for (int i = 0; i < N; i++) if (o_ph[i] == 5 && gi < 0) gi = i;
        e_rv = ack || (gi >= 0);
        if (ack) begin e_rk = 3; e_ra = int'(req_addr); e_rd = int'(req_src); end
        else if (gi >= 0) begin
            e_rk = kind_of(m_cls[gi], m_shr[gi]); e_ra = m_addr[gi]; e_rd = m_src[gi];
        end
        e_mrd = acc && known && (t inside {0, 1, 2, 4, 5}); e_mra = int'(req_addr);
        e_prb = acc && known && (t < 6); e_inv = (t >= 2 && t <= 5); e_pa = int'(req_addr);
        e_err = acc && !known;
        e_mwr = 0;
        for (int i = 0; i < N; i++) begin
            bit mm, pp, hh, vv, uu, dn;
            if (o_ph[i] == 0) continue;
            mm = mem_valid && !mem_wback && int'(mem_addr) == m_addr[i];
            pp = rsp_valid && rsp_kind == 1 && int'(rsp_addr) == m_addr[i];
            hh = rsp_valid && rsp_hit && rsp_kind != 2 && int'(rsp_addr) == m_addr[i];
            vv = rsp_valid && rsp_kind == 2 && int'(rsp_addr) == m_addr[i];
            uu = unb_valid && int'(unb_addr) == m_addr[i];
            if (hh) m_shr[i] = 1;
            dn = 0;
            case (o_ph[i])
                1: if (vv) begin m_ph[i] = 0; e_mwr = 1; e_mwa = m_addr[i]; end
                2: if (mm && pp) dn = 1; else if (mm) m_ph[i] = 4; else if (pp) m_ph[i] = 3;
                3: if (mm) dn = 1;
                4: if (pp) dn = 1;
                5: if (i == gi) m_ph[i] = (m_cls[i] == 5) ? 0 : 6;
                6: if (uu) m_ph[i] = 0;
                default: ;
            endcase
            if (dn) m_ph[i] = (m_cls[i] == 4) ? 0 : 5;
        end
        if (acc && known) begin
            fi = -1;
            for (int i = 0; i < N; i++) if (o_ph[i] == 0 && fi < 0) fi = i;
            m_ph[fi] = (t >= 6) ? 1 : (t == 3) ? 4 : 2;
            m_cls[fi] = t; m_addr[fi] = int'(req_addr);
            m_src[fi] = int'(req_src); m_shr[fi] = req_fshr;
        end
    endtask

    task automatic compare();
        chk(int'(resp_valid) == e_rv, "R3 resp_valid", resp_valid, e_rv);
        if (e_rv && resp_valid) begin
            chk(int'(resp_kind) == e_rk, "R4 resp_kind", resp_kind, e_rk);
            chk(int'(resp_addr) == e_ra, "R3 resp_addr", resp_addr, e_ra);
            chk(int'(resp_dst) == e_rd, "R3 resp_dst", resp_dst, e_rd);
        end
        chk(int'(mrd_valid) == e_mrd, "R2 mrd_valid", mrd_valid, e_mrd);
        if (e_mrd) chk(int'(mrd_addr) == e_mra, "R2 mrd_addr", mrd_addr, e_mra);
        chk(int'(prb_valid) == e_prb, "R2 prb_valid", prb_valid, e_prb);
        if (e_prb) begin
            chk(int'(prb_inv) == e_inv, "R2 prb_inv", prb_inv, e_inv);
            chk(int'(prb_addr) == e_pa, "R2 prb_addr", prb_addr, e_pa);
        end
        chk(int'(mwr_valid) == e_mwr, "R7 mwr_valid", mwr_valid, e_mwr);
        if (e_mwr) chk(int'(mwr_addr) == e_mwa, "R7 mwr_addr", mwr_addr, e_mwa);
        chk(int'(err) == e_err, "R12 err", err, e_err);
        last_mwr = mwr_valid;
        last_err = err;
        if (resp_valid) begin
            resp_count++; last_kind = resp_kind; last_addr = resp_addr;
            log_addr.push_back(int'(resp_addr));
        end
    endtask

    task automatic tick();
        #1;
        seen_ready = req_ready;
        chk(int'(req_ready) == model_ready(), "R6 req_ready", req_ready, model_ready());
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        req_valid = 0; rsp_valid = 0; mem_valid = 0; unb_valid = 0;
        rsp_hit = 0; mem_wback = 0; req_fshr = 0;
    endtask

    task automatic req(input int t, input int a, input int s, input bit f);
        req_valid = 1; req_type = 4'(t); req_addr = AW'(a); req_src = SW'(s); req_fshr = f;
    endtask
    task automatic rsp(input int k, input int a, input bit h);
        rsp_valid = 1; rsp_kind = 2'(k); rsp_addr = AW'(a); rsp_hit = h;
    endtask
    task automatic mem(input int a, input bit wb);
        mem_valid = 1; mem_addr = AW'(a); mem_wback = wb;
    endtask
    task automatic unb(input int a);
        unb_valid = 1; unb_addr = AW'(a);
    endtask
    task automatic peek_ready(input int a);
        req_addr = AW'(a);
        tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        for (int i = 0; i < N; i++) m_ph[i] = 0;
        repeat (3) tick();
        chk(resp_valid == 0 && mrd_valid == 0 && mwr_valid == 0 && prb_valid == 0 && err == 0,
            "R1 outputs in reset", resp_valid, 0);
        rst = 0;
        tick();
        chk(seen_ready == 1, "R1 ready after reset", seen_ready, 1);

        // read-shared: memory first, then probes
        req(0, 'h10, 1, 0); tick();
        mem('h10, 0); tick();
        rsp(1, 'h10, 0); tick();
        tick();
        chk(last_kind == 0 && last_addr == 'h10, "R4 read-shared gives Shared", last_kind, 0);
        peek_ready('h10);
        chk(seen_ready == 0, "R5 busy until unblock", seen_ready, 0);
        unb('h10); tick();
        peek_ready('h10);
        chk(seen_ready == 1, "R5 free after unblock", seen_ready, 1);

        // plain reads: probe hit, no hit, forced shared
        req(1, 'h20, 3, 0); tick();
        rsp(0, 'h20, 1); tick();
        rsp(1, 'h20, 0); tick();
        mem('h20, 0); tick(); tick();
        chk(last_kind == 0, "R4 plain read with hit gives Shared", last_kind, 0);
        unb('h20); tick();
        req(1, 'h30, 3, 0); tick();
        rsp(1, 'h30, 0); tick();
        mem('h30, 0); tick(); tick();
        chk(last_kind == 1, "R4 plain read without hit gives Exclusive", last_kind, 1);
        unb('h30); tick();
        req(1, 'h40, 3, 1); tick();
        mem('h40, 0); tick();
        rsp(1, 'h40, 0); tick(); tick();
        chk(last_kind == 0, "R4 forced sharing gives Shared", last_kind, 0);
        unb('h40); tick();

        // read-modify, both completions in one cycle
        req(2, 'h50, 2, 0); tick();
        mem('h50, 0); rsp(1, 'h50, 0); tick(); tick();
        chk(last_kind == 2 && last_addr == 'h50, "R3 same-cycle completion", last_kind, 2);

        // change-to-dirty: probes only
        n0 = resp_count;
        req(3, 'h60, 4, 0); tick();
        chk(mrd_valid == 0 && prb_inv == 1, "R2 change-to-dirty reads nothing", mrd_valid, 0);
        rsp(1, 'h60, 0); tick(); tick();
        chk(last_kind == 2 && resp_count == n0 + 1, "R4 change-to-dirty Modified", last_kind, 2);
        unb('h60); tick();

        // fill the table ('h50 still waits for unblock)
        req(1, 'h71, 1, 0); tick();
        req(1, 'h72, 2, 0); tick();
        req(1, 'h73, 3, 0); tick();
        peek_ready('h99);
        chk(seen_ready == 0, "R6 full table stalls", seen_ready, 0);
        unb('h50); tick();
        peek_ready('h99);
        chk(seen_ready == 1, "R6 slot freed", seen_ready, 1);

        // two completions together, then a victim ack competes
        rsp(1, 'h71, 0); tick();
        mem('h72, 0); tick();
        mem('h71, 0); rsp(1, 'h72, 0); tick();
        log_addr.delete();
        req(6, 'h80, 5, 0); tick();
        tick(); tick();
        chk(log_addr.size() == 3, "R13 three responses", log_addr.size(), 3);
        if (log_addr.size() == 3) begin
            chk(log_addr[0] == 'h80, "R13 ack first", log_addr[0], 'h80);
            chk(log_addr[1] == 'h71, "R13 lowest slot next", log_addr[1], 'h71);
            chk(log_addr[2] == 'h72, "R13 then next slot", log_addr[2], 'h72);
        end
        req(7, 'h80, 6, 0); tick();
        chk(seen_ready == 0, "R8 second victim stalls", seen_ready, 0);
        rsp(2, 'h80, 0); tick();
        chk(last_mwr == 1, "R7 victim data written", last_mwr, 1);
        peek_ready('h80);
        chk(seen_ready == 1, "R7 victim entry freed", seen_ready, 1);
        unb('h71); tick();
        unb('h72); tick();
        rsp(1, 'h73, 1); tick();
        mem('h73, 0); tick(); tick();
        unb('h73); tick();

        // write-through
        req(4, 'h90, 7, 0); tick();
        chk(last_kind == 3 && last_addr == 'h90, "R9 early ack", last_kind, 3);
        n0 = resp_count;
        mem('h90, 0); tick();
        rsp(1, 'h90, 0); tick(); tick(); tick();
        chk(resp_count == n0, "R9 no data response", resp_count, n0);
        peek_ready('h90);
        chk(seen_ready == 1, "R9 freed without unblock", seen_ready, 1);

        // atomic
        req(5, 'hA0, 8, 0); tick();
        rsp(1, 'hA0, 0); tick();
        mem('hA0, 0); tick(); tick();
        chk(last_kind == 2 && last_addr == 'hA0, "R10 atomic Modified", last_kind, 2);
        peek_ready('hA0);
        chk(seen_ready == 1, "R10 freed without unblock", seen_ready, 1);

        // memory writeback acknowledgment ignored
        req(0, 'hB0, 9, 0); tick();
        rsp(1, 'hB0, 0); tick();
        n0 = resp_count;
        mem('hB0, 1); tick(); tick(); tick();
        chk(resp_count == n0, "R11 wback ack ignored", resp_count, n0);
        mem('hB0, 0); tick(); tick();
        chk(resp_count == n0 + 1 && last_kind == 0, "R11 real data completes", last_kind, 0);
        unb('hB0); tick();

        // unknown type
        n0 = resp_count;
        req(9, 'hC0, 1, 0); tick();
        chk(last_err == 1, "R12 err raised", last_err, 1);
        peek_ready('hC0);
        chk(seen_ready == 1 && resp_count == n0, "R12 nothing allocated", seen_ready, 1);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule